// File: doc/BRIEF.md
# Vector element extract unit

This unit reads one integer element out of a single vector register and returns it as a scalar result for the integer register file. The caller presents a 32-bit instruction word, the current element-width code, the whole contents of the named vector source register and the value of the scalar index register. The unit checks the instruction pattern and works out how many elements of the current width fit in one register. It then picks the requested element, or returns zero when the index lies past the end of the register. The element is zero-extended and cut to the scalar width.

The unit puts the vector-source and index-register numbers on outputs so that the surrounding pipeline can fetch both operands. Results leave through a one-deep output register with a valid/ready handshake, together with the destination register number and an illegal flag. Register grouping plays no part: only the one named register is ever indexed.

Top module: `vext_unit`

## Requirements
- R1: A request is legal only when instr[31:26]=001100, instr[25]=1, instr[14:12]=010 and instr[6:0]=1010111. Any other word returns a response with res_illegal=1.
- R2: vsrc_sel always shows instr[24:20] and xsrc_sel always shows instr[19:15], combinationally. A response carries instr[11:7] of its request on res_rd.
- R3: Width code (sew) 0, 1, 2 and 3 selects elements of 8, 16, 32 and 64 bits. Codes 4 to 7 give res_illegal=1.
- R4: Element i of width w occupies vreg_data[i*w +: w], with element 0 in the least-significant bits. The returned element is zero-extended.
- R5: When instr[19:15] is zero, element 0 is returned whatever idx_value holds.
- R6: When instr[19:15] is nonzero and idx_value, compared unsigned over all its bits, is at least VLEN/w, the result is zero. No wrap to a lower element takes place.
- R7: A 64-bit element is cut to its low XLEN bits when XLEN is 32.
- R8: req_ready equals !res_valid || res_ready. A request accepted on a clock edge sets res_valid after that edge. While res_valid=1 and res_ready=0, the result and its flags hold steady and no request is taken.
- R9: After reset, res_valid is 0.
- R10: A response with res_illegal=1 carries res_data equal to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can take a request |
| instr | input | 32 | Instruction word |
| sew | input | 3 | Element-width code |
| vreg_data | input | VLEN | Contents of the vector source register |
| idx_value | input | XLEN | Value of the scalar index register |
| vsrc_sel | output | 5 | Vector source register number |
| xsrc_sel | output | 5 | Index register number |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Consumer takes the result |
| res_data | output | XLEN | Extracted element |
| res_rd | output | 5 | Destination register number |
| res_illegal | output | 1 | Request was not a legal extract |

## Verification
The bench builds the unit with VLEN=128 and XLEN=32. This gives 16, 8, 4 and 2 elements per register for the four widths. With XLEN=32, a 64-bit element must lose its upper half. A 32-bit index also has high bits far above the masked selection bits, so an index such as count plus one, or 2^31, shows any wrap instead of zeroing. Random registers and indices sit close to the element count for every width. Directed cases cover the zero index field, bad width codes, broken opcode bits, and a stalled consumer with a new request waiting behind it.

// File: rtl/vext_pkg.sv
package vext_pkg;

  localparam logic [5:0] EXT_FUNCT6 = 6'b001100;
  localparam logic       EXT_VMBIT  = 1'b1;
  localparam logic [2:0] EXT_FUNCT3 = 3'b010;
  localparam logic [6:0] EXT_OPCODE = 7'b1010111;

  localparam int NUM_WIDTHS = 4;

  typedef enum logic [2:0] {
    EW_8  = 3'd0,
    EW_16 = 3'd1,
    EW_32 = 3'd2,
    EW_64 = 3'd3
  } elem_width_e;

  typedef struct packed {
    logic       hit;
    logic [4:0] vsrc;
    logic [4:0] xsrc;
    logic [4:0] dst;
  } ext_fields_t;

endpackage

// File: rtl/vext_decode.sv
module vext_decode
  import vext_pkg::*;
(
  input  logic [31:0]  instr,
  input  logic [2:0]   sew,
  output ext_fields_t  fields,
  output logic         legal,
  output logic         xsrc_zero
);

  logic f6_ok, vm_ok, f3_ok, op_ok, width_ok;

  always_comb begin
    f6_ok    = (instr[31:26] == EXT_FUNCT6);
    vm_ok    = (instr[25] == EXT_VMBIT);
    f3_ok    = (instr[14:12] == EXT_FUNCT3);
    op_ok    = (instr[6:0] == EXT_OPCODE);
    width_ok = (sew <= EW_64);

    fields.hit  = f6_ok & vm_ok & f3_ok & op_ok;
    fields.vsrc = instr[24:20];
    fields.xsrc = instr[19:15];
    fields.dst  = instr[11:7];

    legal     = fields.hit & width_ok;
    xsrc_zero = (instr[19:15] == 5'd0);
  end

endmodule

// File: rtl/vext_index.sv
module vext_index #(
  parameter int VLEN = 128,
  parameter int XLEN = 64
) (
  input  logic [1:0]                      width,
  input  logic                            xsrc_zero,
  input  logic [XLEN-1:0]                 idx_value,
  output logic                            in_range,
  output logic [$clog2(VLEN/8)-1:0]       sel_idx
);

  localparam int MAX_ELEMS = VLEN / 8;
  localparam int IDXW      = $clog2(MAX_ELEMS);
  localparam int CNTW      = IDXW + 1;
  localparam int CMPW      = (XLEN > CNTW) ? XLEN : CNTW;

  logic [CNTW-1:0] elem_count;
  logic [CMPW-1:0] eff_idx;
  logic [CMPW-1:0] cnt_ext;
  logic [IDXW-1:0] idx_mask;

  always_comb begin
    elem_count = CNTW'(MAX_ELEMS >> width);
    cnt_ext    = CMPW'(elem_count);
    eff_idx    = xsrc_zero ? '0 : CMPW'(idx_value);
    idx_mask   = IDXW'(elem_count - CNTW'(1));
    in_range   = (eff_idx < cnt_ext);
    sel_idx    = eff_idx[IDXW-1:0] & idx_mask;
  end

endmodule

// File: rtl/vext_elem_mux.sv
module vext_elem_mux
  import vext_pkg::*;
#(
  parameter int VLEN = 128
) (
  input  logic [VLEN-1:0]               vreg_data,
  input  logic [1:0]                    width,
  input  logic [$clog2(VLEN/8)-1:0]     sel_idx,
  output logic [63:0]                   elem
);

  localparam int IDXW = $clog2(VLEN / 8);

  logic [63:0] per_width [NUM_WIDTHS];

  for (genvar g = 0; g < NUM_WIDTHS; g++) begin : g_width
    localparam int EW  = 8 << g;
    localparam int NE  = VLEN / EW;
    localparam int SW  = (NE > 1) ? $clog2(NE) : 1;

    logic [EW-1:0] lane [NE];
    logic [SW-1:0] lane_sel;

    for (genvar e = 0; e < NE; e++) begin : g_lane
      assign lane[e] = vreg_data[e*EW +: EW];
    end

    if (NE > 1) begin : g_multi
      assign lane_sel = sel_idx[SW-1:0];
    end else begin : g_single
      assign lane_sel = '0;
    end

    assign per_width[g] = 64'(lane[lane_sel]);
  end

  always_comb begin
    elem = per_width[width];
  end

endmodule

// File: rtl/vext_unit.sv
module vext_unit
  import vext_pkg::*;
#(
  parameter int VLEN = 128,
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [31:0]     instr,
  input  logic [2:0]      sew,
  input  logic [VLEN-1:0] vreg_data,
  input  logic [XLEN-1:0] idx_value,
  output logic [4:0]      vsrc_sel,
  output logic [4:0]      xsrc_sel,
  output logic            res_valid,
  input  logic            res_ready,
  output logic [XLEN-1:0] res_data,
  output logic [4:0]      res_rd,
  output logic            res_illegal
);

  localparam int IDXW = $clog2(VLEN / 8);

  ext_fields_t     fields;
  logic            legal;
  logic            xsrc_zero;
  logic            in_range;
  logic [IDXW-1:0] sel_idx;
  logic [63:0]     elem;

  logic            accept;
  logic            valid_nxt;
  logic [XLEN-1:0] data_nxt;
  logic [4:0]      rd_nxt;
  logic            illegal_nxt;
  logic            load_en;

  vext_decode u_decode (
    .instr     (instr),
    .sew       (sew),
    .fields    (fields),
    .legal     (legal),
    .xsrc_zero (xsrc_zero)
  );

  vext_index #(.VLEN(VLEN), .XLEN(XLEN)) u_index (
    .width     (sew[1:0]),
    .xsrc_zero (xsrc_zero),
    .idx_value (idx_value),
    .in_range  (in_range),
    .sel_idx   (sel_idx)
  );

  vext_elem_mux #(.VLEN(VLEN)) u_mux (
    .vreg_data (vreg_data),
    .width     (sew[1:0]),
    .sel_idx   (sel_idx),
    .elem      (elem)
  );

  assign vsrc_sel  = fields.vsrc;
  assign xsrc_sel  = fields.xsrc;
  assign req_ready = ~res_valid | res_ready;

  always_comb begin
    accept      = req_valid & req_ready;
    load_en     = accept;
    valid_nxt   = accept | (res_valid & ~res_ready);
    rd_nxt      = fields.dst;
    illegal_nxt = ~legal;
    if (legal && in_range) begin
      data_nxt = XLEN'(elem);
    end else begin
      data_nxt = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
    end else begin
      res_valid <= valid_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_data    <= '0;
      res_rd      <= '0;
      res_illegal <= 1'b0;
    end else if (load_en) begin
      res_data    <= data_nxt;
      res_rd      <= rd_nxt;
      res_illegal <= illegal_nxt;
    end
  end

endmodule

// File: rtl/vext_unit_chk.sv
module vext_unit_chk #(
  parameter int VLEN = 128,
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic [4:0]      xsrc_field,
  input logic [2:0]      sew,
  input logic [XLEN-1:0] idx_value,
  input logic            res_valid,
  input logic            res_ready,
  input logic [XLEN-1:0] res_data,
  input logic [4:0]      res_rd,
  input logic            res_illegal
);

  logic        took;
  logic [63:0] count64;

  assign took    = req_valid & req_ready;
  assign count64 = 64'(VLEN >> (3 + int'(sew[1:0])));

  AST_RESP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    took |=> res_valid); // R8

  AST_HOLD_WHEN_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_data) && $stable(res_rd) && $stable(res_illegal)); // R8

  AST_NO_TAKE_WHEN_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |-> !req_ready); // R8

  AST_ILLEGAL_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_illegal |-> res_data == '0); // R10

  AST_BAD_WIDTH_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    took && sew[2] |=> res_illegal); // R3

  AST_OUT_OF_RANGE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    took && !sew[2] && (xsrc_field != 5'd0) && (64'(idx_value) >= count64) |=> res_data == '0); // R6

  AST_BYTE_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    took && (sew == 3'd0) |=> res_data[XLEN-1:8] == '0); // R4

endmodule

bind vext_unit vext_unit_chk #(.VLEN(VLEN), .XLEN(XLEN)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .xsrc_field  (instr[19:15]),
  .sew         (sew),
  .idx_value   (idx_value),
  .res_valid   (res_valid),
  .res_ready   (res_ready),
  .res_data    (res_data),
  .res_rd      (res_rd),
  .res_illegal (res_illegal)
);

// File: tb/vext_unit_bench.sv
module vext_unit_bench;

  localparam int VLEN = 128;
  localparam int XLEN = 32;

  logic            clk;
  logic            rst_n;
  logic            req_valid;
  logic            req_ready;
  logic [31:0]     instr;
  logic [2:0]      sew;
  logic [VLEN-1:0] vreg_data;
  logic [XLEN-1:0] idx_value;
  logic [4:0]      vsrc_sel;
  logic [4:0]      xsrc_sel;
  logic            res_valid;
  logic            res_ready;
  logic [XLEN-1:0] res_data;
  logic [4:0]      res_rd;
  logic            res_illegal;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  vext_unit #(.VLEN(VLEN), .XLEN(XLEN)) u_vext_unit (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(string rq, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(logic [4:0] vs, logic [4:0] xs, logic [4:0] rd);
    return {6'b001100, 1'b1, vs, xs, 3'b010, rd, 7'b1010111};
  endfunction

  // returns {illegal, data}
  function automatic logic [XLEN:0] model(logic [31:0] ins, logic [2:0] w,
                                          logic [VLEN-1:0] v, logic [XLEN-1:0] ix);
    int ew;
    longint unsigned cnt, i;
    logic [63:0] e;
    if (ins[31:26] != 6'b001100 || ins[25] != 1'b1 || ins[14:12] != 3'b010 ||
        ins[6:0] != 7'b1010111 || w > 3'd3)
      return {1'b1, {XLEN{1'b0}}};
    ew  = 8 << w;
    cnt = longint'(VLEN / ew);
    i   = (ins[19:15] == 5'd0) ? 0 : longint'(ix);
    if (i >= cnt) return {1'b0, {XLEN{1'b0}}};
    e = '0;
    for (int b = 0; b < 64; b++)
      if (b < ew) e[b] = v[int'(i) * ew + b];
    return {1'b0, e[XLEN-1:0]};
  endfunction

  function automatic logic [VLEN-1:0] rnd_vreg();
    logic [VLEN-1:0] v;
    for (int k = 0; k < VLEN / 32; k++) v[k*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic run_one(string rq, logic [31:0] ins, logic [2:0] w,
                         logic [VLEN-1:0] v, logic [XLEN-1:0] ix);
    logic [XLEN:0] e;
    e = model(ins, w, v, ix);
    @(negedge clk);
    instr = ins; sew = w; vreg_data = v; idx_value = ix; req_valid = 1'b1;
    #1;
    chk({rq, " R2 vsrc"}, 64'(vsrc_sel), 64'(ins[24:20]));
    chk({rq, " R2 xsrc"}, 64'(xsrc_sel), 64'(ins[19:15]));
    @(negedge clk);
    req_valid = 1'b0;
    chk({rq, " R8 valid"}, 64'(res_valid), 64'(1));
    chk({rq, " R1 illegal"}, 64'(res_illegal), 64'(e[XLEN]));
    chk({rq, " data"}, 64'(res_data), 64'(e[XLEN-1:0]));
    if (!e[XLEN]) chk({rq, " R2 rd"}, 64'(res_rd), 64'(ins[11:7]));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [VLEN-1:0] v;
    logic [XLEN:0]   e1, e2;
    logic [31:0]     i1, i2;
    void'($urandom(32'd4242));
    rst_n = 1'b0; req_valid = 1'b0; res_ready = 1'b1;
    instr = '0; sew = '0; vreg_data = '0; idx_value = '0;
    repeat (3) @(negedge clk);
    chk("R9 reset valid", 64'(res_valid), 64'(0));
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 idle after reset", 64'(res_valid), 64'(0));

    v = rnd_vreg();
    // R4 positions for each width, last element in range
    for (int w = 0; w < 4; w++) begin
      run_one("R4 first", mk(5'd3, 5'd7, 5'd9), 3'(w), v, 0);
      run_one("R4 last", mk(5'd3, 5'd7, 5'd9), 3'(w), v, XLEN'((VLEN >> (3 + w)) - 1));
      run_one("R6 at count", mk(5'd3, 5'd7, 5'd9), 3'(w), v, XLEN'(VLEN >> (3 + w)));
      run_one("R6 count plus one", mk(5'd3, 5'd7, 5'd9), 3'(w), v, XLEN'((VLEN >> (3 + w)) + 1));
      run_one("R6 high bit", mk(5'd3, 5'd7, 5'd9), 3'(w), v, 32'h8000_0001);
    end
    // R5 zero index field ignores idx_value
    run_one("R5 zero field", mk(5'd1, 5'd0, 5'd4), 3'd0, v, 32'hFFFF_FFFF);
    run_one("R5 zero field wide", mk(5'd1, 5'd0, 5'd4), 3'd2, v, 32'd3);
    // R7 64-bit element truncated
    run_one("R7 trunc", mk(5'd2, 5'd5, 5'd6), 3'd3, v, 32'd1);
    // R3 undefined widths
    run_one("R3 width4", mk(5'd2, 5'd5, 5'd6), 3'd4, v, 32'd0);
    run_one("R3 width7", mk(5'd2, 5'd5, 5'd6), 3'd7, v, 32'd0);
    // R1 broken pattern bits
    run_one("R1 bit25", mk(5'd2, 5'd5, 5'd6) & ~32'h0200_0000, 3'd0, v, 32'd0);
    run_one("R1 funct3", mk(5'd2, 5'd5, 5'd6) ^ 32'h0000_1000, 3'd1, v, 32'd0);
    run_one("R1 opcode", mk(5'd2, 5'd5, 5'd6) ^ 32'h0000_0001, 3'd1, v, 32'd0);
    run_one("R1 funct6", mk(5'd2, 5'd5, 5'd6) ^ 32'h0400_0000, 3'd1, v, 32'd0);

    // R8 stall with a second request waiting
    v  = rnd_vreg();
    i1 = mk(5'd8, 5'd9, 5'd10);
    i2 = mk(5'd8, 5'd9, 5'd11);
    e1 = model(i1, 3'd1, v, 32'd2);
    e2 = model(i2, 3'd0, v, 32'd15);
    @(negedge clk);
    res_ready = 1'b0;
    instr = i1; sew = 3'd1; vreg_data = v; idx_value = 32'd2; req_valid = 1'b1;
    @(negedge clk);
    instr = i2; sew = 3'd0; idx_value = 32'd15;
    for (int k = 0; k < 3; k++) begin
      chk("R8 stall valid", 64'(res_valid), 64'(1));
      chk("R8 stall ready low", 64'(req_ready), 64'(0));
      chk("R8 stall data", 64'(res_data), 64'(e1[XLEN-1:0]));
      chk("R8 stall rd", 64'(res_rd), 64'(10));
      @(negedge clk);
    end
    res_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R8 second data", 64'(res_data), 64'(e2[XLEN-1:0]));
    chk("R8 second rd", 64'(res_rd), 64'(11));
    @(negedge clk);
    chk("R8 drained", 64'(res_valid), 64'(0));

    // random mix around the element count
    for (int n = 0; n < 400; n++) begin
      logic [31:0] ins;
      logic [2:0]  w;
      logic [XLEN-1:0] ix;
      int cnt;
      ins = mk(5'($urandom), ($urandom % 4 == 0) ? 5'd0 : 5'($urandom), 5'($urandom));
      if ($urandom % 16 == 0) ins = ins ^ (32'd1 << ($urandom % 32));
      w   = ($urandom % 10 == 0) ? 3'(4 + $urandom % 4) : 3'($urandom % 4);
      cnt = VLEN >> (3 + int'(w[1:0]));
      case ($urandom % 3)
        0: ix = XLEN'($urandom % cnt);
        1: ix = XLEN'(cnt + $urandom % 4);
        default: ix = XLEN'($urandom);
      endcase
      run_one("R4 R6 random", ins, w, rnd_vreg(), ix);
    end

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule